// File: doc/BRIEF.md
# Tag Cache Front End with Leading/Following Access Classifier

This block sits between the last on-chip cache level and a set-associative DRAM cache whose tags live in DRAM rows. It keeps a small on-chip cache of tag batches, where one batch holds every way tag of one DRAM-cache set. Each request names a set, a section and a block tag. If the batch for that set is on chip, the request is answered in the next cycle with a hit or miss and the matched way. If the batch is not on chip, one fetch of the whole batch is issued through a request/response handshake, and the request is answered once the batch is installed.

Every answer also carries a label. A request that finds its set neither resident nor already being fetched starts a new tag batch fetch and is labelled leading. Any other request is labelled following: requests to a resident set, and requests to a set whose fetch is still in flight. The following label holds even when the block itself is absent from the batch. A set, and with it every section mapped onto it, becomes inactive again only when its batch is evicted from the tag cache. A miss on a resident batch means that the block goes directly to off-chip memory, with no probe of the DRAM cache.

Top module: `tagc_classify`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, rsp_valid is 0 and fetch_req_valid is 0.
- R2: A request accepted for a resident set whose batch holds the request tag in a way with its valid bit set gets rsp_valid one cycle later, with rsp_hit 1, rsp_way equal to that way index and rsp_lead 0.
- R3: A request to a resident set whose tag is absent from the batch, or present only in a way whose valid bit is clear, gets rsp_hit 0 (route to off-chip memory) and rsp_lead 0, and no fetch is issued.
- R4: A request accepted for a set that is neither resident nor being fetched raises fetch_req_valid with fetch_req_set equal to that set, and its response carries rsp_lead 1.
- R5: fetch_req_valid and fetch_req_set stay unchanged until fetch_req_ready is seen, and at most one batch fetch is outstanding.
- R6: While a fetch is pending, requests to the same set are accepted, labelled following, and answered after the install in acceptance order, with no second fetch.
- R7: While a fetch is pending, req_ready is 0 whenever req_set differs from the pending set.
- R8: Responses held for a fetch take their hit and way from the installed batch: fetch_rsp_tags carries way w at bits [w*TAG_W +: TAG_W], and bit w of fetch_rsp_vld marks way w valid.
- R9: An install fills an empty entry first, or else evicts the least recently used batch, where every response that looks up a resident set counts as a use; the next request to an evicted set is leading again.
- R10: The queue of requests waiting on a fetch (the leading one included) holds WQ_DEPTH entries; when it is full, req_ready is 0 even for the pending set.
- R11: rsp_sect equals the section of the request being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_set | input | SET_W | DRAM-cache set index of the request |
| req_sect | input | SECT_W | Section identifier, echoed in the answer |
| req_tag | input | TAG_W | Block tag to match |
| fetch_req_valid | output | 1 | Tag batch fetch requested |
| fetch_req_ready | input | 1 | Fetch request taken |
| fetch_req_set | output | SET_W | Set whose batch is fetched |
| fetch_rsp_valid | input | 1 | Fetched batch present (one cycle) |
| fetch_rsp_tags | input | WAYS*TAG_W | Way tags of the fetched batch |
| fetch_rsp_vld | input | WAYS | Per-way valid bits of the fetched batch |
| rsp_valid | output | 1 | Answer present (one cycle) |
| rsp_hit | output | 1 | 1 = block in DRAM cache, 0 = go to memory |
| rsp_way | output | $clog2(WAYS) | Matched way when rsp_hit is 1 |
| rsp_lead | output | 1 | 1 = leading access, 0 = following |
| rsp_sect | output | SECT_W | Section of the answered request |

## Verification
Corrupted residency or recency state shows up as a wrong rsp_lead label. It can also show up as an extra or missing fetch_req_valid. For a resident set this appears on the answer one cycle after acceptance; after an eviction, it appears on the first revisit of the evicted set. A wrong wait-queue order or lost entry shows up as answers whose rsp_sect or hit does not match acceptance order. These appear within the drain that follows the install. A wrong blocking rule shows up at once on req_ready, while the fetch is pending.

// File: rtl/tagc_pkg.sv
// Shared types for the tag cache front end.
// Assumes: nothing beyond a single clock domain.
package tagc_pkg;
    // Controller phases: idle lookup, asking for a fetch, waiting for the batch, draining waiters
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ASK   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DRAIN = 2'd3
    } tc_state_e;
endpackage

// File: rtl/tagc_store.sv
// Tag batch storage: ENTRIES entries, each a valid bit, a set index and WAYS tags
// with per-way valid bits. Combinational lookup, one install or one recency touch per cycle.
// Recency is a permutation of ages 0..ENTRIES-1 (0 = most recent).
// Assumes: ENTRIES >= 2, the controller never installs a set that is already resident,
// and install and touch are never requested in the same cycle.
module tagc_store #(
    parameter int SET_W   = 10,
    parameter int TAG_W   = 12,
    parameter int WAYS    = 8,
    parameter int ENTRIES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SET_W-1:0]        lk_set,
    input  logic [TAG_W-1:0]        lk_tag,
    output logic                    lk_res,
    output logic                    lk_hit,
    output logic [$clog2(WAYS)-1:0] lk_way,
    output logic [$clog2(ENTRIES)-1:0] lk_ent,
    input  logic                    touch_en,
    input  logic [$clog2(ENTRIES)-1:0] touch_ent,
    input  logic                    inst_en,
    input  logic [SET_W-1:0]        inst_set,
    input  logic [WAYS*TAG_W-1:0]   inst_tags,
    input  logic [WAYS-1:0]         inst_vld
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int ENT_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] ent_v;
    logic [SET_W-1:0]   ent_set [ENTRIES];
    logic [TAG_W-1:0]   ent_tag [ENTRIES][WAYS];
    logic [WAYS-1:0]    ent_wv  [ENTRIES];
    logic [ENT_W-1:0]   age_q   [ENTRIES];
    logic [ENTRIES-1:0] ent_match;
    logic [ENT_W-1:0]   vict;
    logic [ENT_W-1:0]   upd_ent;
    logic               upd_go;

    // Per-entry set comparison
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_match
            assign ent_match[g] = ent_v[g] && (ent_set[g] == lk_set);
        end
    endgenerate

    // Lookup: resident entry, then first valid way whose tag matches
    always_comb begin
        lk_res = 1'b0;
        lk_ent = '0;
        lk_hit = 1'b0;
        lk_way = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (ent_match[e]) begin
                lk_res = 1'b1;
                lk_ent = ENT_W'(e);
                for (int w = 0; w < WAYS; w++) begin
                    if (!lk_hit && ent_wv[e][w] && ent_tag[e][w] == lk_tag) begin
                        lk_hit = 1'b1;
                        lk_way = WAY_W'(w);
                    end
                end
            end
        end
    end

    // Victim choice: lowest empty entry, else the oldest one
    always_comb begin
        logic found;
        found = 1'b0;
        vict  = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (!found && !ent_v[e]) begin
                found = 1'b1;
                vict  = ENT_W'(e);
            end
        end
        if (!found) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (age_q[e] == ENT_W'(ENTRIES-1)) vict = ENT_W'(e);
            end
        end
    end

    // Which entry becomes most recent this cycle
    always_comb begin
        upd_go  = inst_en || touch_en;
        upd_ent = inst_en ? vict : touch_ent;
    end

    // Entry contents: written on install only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v <= '0;
        end else if (inst_en) begin
            ent_v[vict]   <= 1'b1;
            ent_set[vict] <= inst_set;
            ent_wv[vict]  <= inst_vld;
            for (int w = 0; w < WAYS; w++) begin
                ent_tag[vict][w] <= inst_tags[w*TAG_W +: TAG_W];
            end
        end
    end

    // Recency ages: the updated entry goes to 0, younger ones age by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) age_q[e] <= ENT_W'(e);
        end else if (upd_go) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (ENT_W'(e) == upd_ent)          age_q[e] <= '0;
                else if (age_q[e] < age_q[upd_ent]) age_q[e] <= age_q[e] + 1'b1;
            end
        end
    end

    // R9: a set never occupies two entries
    a_r9_unique_set: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ent_match));
    // R9: a touched entry is most recent on the next cycle
    a_r9_touch_recent: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en && !inst_en |=> age_q[$past(touch_ent)] == '0);
endmodule

// File: rtl/tagc_waitq.sv
// FIFO of requests waiting on a pending tag batch fetch. Each item is packed
// {section, tag, leading}. Assumes push and pop never coincide and that the
// controller never pushes when full nor pops when empty.
module tagc_waitq #(
    parameter int ITEM_W = 19,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ITEM_W-1:0] push_data,
    input  logic              pop,
    output logic [ITEM_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ITEM_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q;
    logic [CNT_W-1:0]  cnt_q;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign head  = mem[rd_q];

    // Storage write
    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= push_data;
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                wr_q  <= (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
                cnt_q <= cnt_q + 1'b1;
            end else if (pop) begin
                rd_q  <= (rd_q == PTR_W'(DEPTH-1)) ? '0 : rd_q + 1'b1;
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R10: never written beyond capacity
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full));
    // R6: never drained past empty
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));
endmodule

// File: rtl/tagc_ctrl.sv
// Controller: accepts requests, answers resident sets at once, starts one tag
// batch fetch for a non-resident set, parks same-set requests while it is pending,
// installs the batch and drains the parked requests in order.
// Assumes: fetch_rsp_valid arrives only after fetch_req_ready was given.
module tagc_ctrl
    import tagc_pkg::*;
#(
    parameter int SET_W  = 10,
    parameter int SECT_W = 6,
    parameter int TAG_W  = 12,
    parameter int WAY_W  = 3,
    parameter int ENT_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [SET_W-1:0]            req_set,
    input  logic [SECT_W-1:0]           req_sect,
    input  logic [TAG_W-1:0]            req_tag,
    output logic                        req_ready,
    output logic [SET_W-1:0]            lk_set,
    output logic [TAG_W-1:0]            lk_tag,
    input  logic                        lk_res,
    input  logic                        lk_hit,
    input  logic [WAY_W-1:0]            lk_way,
    input  logic [ENT_W-1:0]            lk_ent,
    output logic                        touch_en,
    output logic [ENT_W-1:0]            touch_ent,
    output logic                        inst_en,
    output logic [SET_W-1:0]            inst_set,
    output logic                        wq_push,
    output logic [SECT_W+TAG_W:0]       wq_push_data,
    output logic                        wq_pop,
    input  logic [SECT_W+TAG_W:0]       wq_head,
    input  logic                        wq_empty,
    input  logic                        wq_full,
    output logic                        fetch_req_valid,
    output logic [SET_W-1:0]            fetch_req_set,
    input  logic                        fetch_req_ready,
    input  logic                        fetch_rsp_valid,
    output logic                        rsp_valid,
    output logic                        rsp_hit,
    output logic [WAY_W-1:0]            rsp_way,
    output logic                        rsp_lead,
    output logic [SECT_W-1:0]           rsp_sect
);
    tc_state_e         state_q;
    logic [SET_W-1:0]  pend_q;
    logic              in_idle, pending, draining;
    logic              idle_acc, idle_hitpath, idle_miss;
    logic [SECT_W-1:0] head_sect;
    logic [TAG_W-1:0]  head_tag;
    logic              head_lead;

    assign in_idle  = (state_q == ST_IDLE);
    assign pending  = (state_q == ST_ASK) || (state_q == ST_WAIT);
    assign draining = (state_q == ST_DRAIN);
    assign {head_sect, head_tag, head_lead} = wq_head;

    // Ready rule: free in idle, same set with room while pending, closed while draining
    always_comb begin
        if (in_idle)      req_ready = 1'b1;
        else if (pending) req_ready = (req_set == pend_q) && !wq_full;
        else              req_ready = 1'b0;
    end

    // Lookup source: live request, or queue head against the pending set
    always_comb begin
        lk_set = draining ? pend_q   : req_set;
        lk_tag = draining ? head_tag : req_tag;
    end

    // Acceptance decode for the idle phase
    always_comb begin
        idle_acc     = in_idle && req_valid;
        idle_hitpath = idle_acc && lk_res;
        idle_miss    = idle_acc && !lk_res;
    end

    // Queue, recency and install controls
    always_comb begin
        wq_push      = idle_miss || (pending && req_valid && req_ready);
        wq_push_data = {req_sect, req_tag, in_idle};
        wq_pop       = draining && !wq_empty;
        touch_en     = idle_hitpath || (wq_pop && lk_res);
        touch_ent    = lk_ent;
        inst_en      = (state_q == ST_WAIT) && fetch_rsp_valid;
        inst_set     = pend_q;
    end

    assign fetch_req_valid = (state_q == ST_ASK);
    assign fetch_req_set   = pend_q;

    // Phase sequencing and capture of the pending set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (idle_miss) begin
                    state_q <= ST_ASK;
                    pend_q  <= req_set;
                end
                ST_ASK:   if (fetch_req_ready) state_q <= ST_WAIT;
                ST_WAIT:  if (fetch_rsp_valid) state_q <= ST_DRAIN;
                ST_DRAIN: if (wq_empty)        state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Answer register: one cycle after a resident lookup or a drain pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_lead  <= 1'b0;
            rsp_sect  <= '0;
        end else begin
            rsp_valid <= idle_hitpath || wq_pop;
            if (idle_hitpath || wq_pop) begin
                rsp_hit  <= lk_hit;
                rsp_way  <= lk_way;
                rsp_lead <= draining ? head_lead : 1'b0;
                rsp_sect <= draining ? head_sect : req_sect;
            end
        end
    end

    // R5: a fetch request is held steady until taken
    a_r5_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_valid && !fetch_req_ready |=> fetch_req_valid && $stable(fetch_req_set));
    // R6: an install is never followed by a fresh fetch for the same drain
    a_r6_no_refetch: assert property (@(posedge clk) disable iff (!rst_n)
        inst_en |=> !fetch_req_valid);
    // R7: other sets are held off while a fetch is outstanding
    a_r7_block_other: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_valid && (req_set != fetch_req_set) |-> !req_ready);
    // R4: an idle miss is followed by a fetch request for that set
    a_r4_miss_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        idle_miss |=> fetch_req_valid && fetch_req_set == $past(req_set));
endmodule

// File: rtl/tagc_classify.sv
// Top of the tag cache front end: ties the controller, the batch store and
// the wait queue together. Requests answer in order with hit, way and a
// leading/following label. Assumes WQ_DEPTH >= 1, WAYS >= 2, ENTRIES >= 2.
module tagc_classify #(
    parameter int SET_W    = 10,
    parameter int SECT_W   = 6,
    parameter int TAG_W    = 12,
    parameter int WAYS     = 8,
    parameter int ENTRIES  = 4,
    parameter int WQ_DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [SET_W-1:0]        req_set,
    input  logic [SECT_W-1:0]       req_sect,
    input  logic [TAG_W-1:0]        req_tag,
    output logic                    fetch_req_valid,
    input  logic                    fetch_req_ready,
    output logic [SET_W-1:0]        fetch_req_set,
    input  logic                    fetch_rsp_valid,
    input  logic [WAYS*TAG_W-1:0]   fetch_rsp_tags,
    input  logic [WAYS-1:0]         fetch_rsp_vld,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic [$clog2(WAYS)-1:0] rsp_way,
    output logic                    rsp_lead,
    output logic [SECT_W-1:0]       rsp_sect
);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int ENT_W  = $clog2(ENTRIES);
    localparam int ITEM_W = SECT_W + TAG_W + 1;

    logic [SET_W-1:0]  lk_set;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_res, lk_hit;
    logic [WAY_W-1:0]  lk_way;
    logic [ENT_W-1:0]  lk_ent, touch_ent;
    logic              touch_en, inst_en;
    logic [SET_W-1:0]  inst_set;
    logic              wq_push, wq_pop, wq_empty, wq_full;
    logic [ITEM_W-1:0] wq_push_data, wq_head;

    tagc_ctrl #(
        .SET_W(SET_W), .SECT_W(SECT_W), .TAG_W(TAG_W), .WAY_W(WAY_W), .ENT_W(ENT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_set(req_set), .req_sect(req_sect), .req_tag(req_tag),
        .req_ready(req_ready),
        .lk_set(lk_set), .lk_tag(lk_tag), .lk_res(lk_res), .lk_hit(lk_hit),
        .lk_way(lk_way), .lk_ent(lk_ent),
        .touch_en(touch_en), .touch_ent(touch_ent), .inst_en(inst_en), .inst_set(inst_set),
        .wq_push(wq_push), .wq_push_data(wq_push_data), .wq_pop(wq_pop),
        .wq_head(wq_head), .wq_empty(wq_empty), .wq_full(wq_full),
        .fetch_req_valid(fetch_req_valid), .fetch_req_set(fetch_req_set),
        .fetch_req_ready(fetch_req_ready), .fetch_rsp_valid(fetch_rsp_valid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_lead(rsp_lead), .rsp_sect(rsp_sect)
    );

    tagc_store #(
        .SET_W(SET_W), .TAG_W(TAG_W), .WAYS(WAYS), .ENTRIES(ENTRIES)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_set(lk_set), .lk_tag(lk_tag), .lk_res(lk_res), .lk_hit(lk_hit),
        .lk_way(lk_way), .lk_ent(lk_ent),
        .touch_en(touch_en), .touch_ent(touch_ent),
        .inst_en(inst_en), .inst_set(inst_set),
        .inst_tags(fetch_rsp_tags), .inst_vld(fetch_rsp_vld)
    );

    tagc_waitq #(
        .ITEM_W(ITEM_W), .DEPTH(WQ_DEPTH)
    ) u_waitq (
        .clk(clk), .rst_n(rst_n),
        .push(wq_push), .push_data(wq_push_data), .pop(wq_pop),
        .head(wq_head), .empty(wq_empty), .full(wq_full)
    );
endmodule

// File: tb/sim_tagc_classify.sv
// Scoreboard bench: the driver computes each expected answer from an
// independent recency-list model and queues it; a monitor compares answers.
module sim_tagc_classify;
    localparam int SET_W = 10, SECT_W = 6, TAG_W = 12, WAYS = 8, ENTRIES = 4, WQ = 4;
    localparam int FLAT = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [SET_W-1:0] req_set = '0;
    logic [SECT_W-1:0] req_sect = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic fetch_req_valid;
    logic fetch_req_ready = 1'b0;
    logic [SET_W-1:0] fetch_req_set;
    logic fetch_rsp_valid = 1'b0;
    logic [WAYS*TAG_W-1:0] fetch_rsp_tags = '0;
    logic [WAYS-1:0] fetch_rsp_vld = '0;
    logic rsp_valid, rsp_hit, rsp_lead;
    logic [2:0] rsp_way;
    logic [SECT_W-1:0] rsp_sect;

    int checks = 0;
    int fails = 0;
    string phase = "";

    typedef struct { bit hit; int way; bit lead; int sect; } exp_t;
    exp_t exq[$];
    int   fexq[$];
    int   lru[$];

    always #10 clk = ~clk;

    tagc_classify u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_set(req_set), .req_sect(req_sect), .req_tag(req_tag),
        .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
        .fetch_req_set(fetch_req_set), .fetch_rsp_valid(fetch_rsp_valid),
        .fetch_rsp_tags(fetch_rsp_tags), .fetch_rsp_vld(fetch_rsp_vld),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_lead(rsp_lead), .rsp_sect(rsp_sect)
    );

    function automatic int btag(int s, int w);
        return (s * 8 + w + 16) & 12'hfff;
    endfunction
    function automatic bit bvld(int s, int w);
        return w != (s % 8);
    endfunction

    task automatic chk(bit ok, string rq, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s %s: actual %0d expected %0d", rq, phase, what, act, expv);
        end
    endtask

    // Model acceptance: residency via recency list (R9), label (R4/R6), hit (R2/R3/R8)
    task automatic model_accept(int s, int sect, int tag);
        exp_t e;
        int idx = -1;
        foreach (lru[k]) if (lru[k] == s) idx = k;
        e.lead = (idx < 0);
        if (idx >= 0) lru.delete(idx);
        lru.push_front(s);
        if (lru.size() > ENTRIES) void'(lru.pop_back());
        if (e.lead) fexq.push_back(s);
        e.hit = 1'b0;
        e.way = 0;
        for (int w = 0; w < WAYS; w++) begin
            if (!e.hit && bvld(s, w) && btag(s, w) == tag) begin
                e.hit = 1'b1;
                e.way = w;
            end
        end
        e.sect = sect;
        exq.push_back(e);
    endtask

    task automatic send(int s, int sect, int tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_set = SET_W'(s);
        req_sect = SECT_W'(sect);
        req_tag = TAG_W'(tag);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        model_accept(s, sect, tag);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic probe_ready(int s, bit expv, string rq);
        @(negedge clk);
        req_valid = 1'b0;
        req_set = SET_W'(s);
        #1;
        chk(req_ready === expv, rq, "req_ready", int'(req_ready), int'(expv));
    endtask

    // Monitor: compare each answer with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exq.size() == 0) begin
                chk(1'b0, "R2", "unexpected answer", 1, 0);
            end else begin
                exp_t e;
                string rq;
                e = exq.pop_front();
                rq = e.lead ? "R4/R8/R9" : (e.hit ? "R2/R6" : "R3/R6");
                chk(rsp_hit === e.hit, rq, "rsp_hit", int'(rsp_hit), int'(e.hit));
                if (e.hit) chk(int'(rsp_way) == e.way, rq, "rsp_way", int'(rsp_way), e.way);
                chk(rsp_lead === e.lead, rq, "rsp_lead", int'(rsp_lead), int'(e.lead));
                chk(int'(rsp_sect) == e.sect, "R11", "rsp_sect", int'(rsp_sect), e.sect);
            end
        end
    end

    // Fetch responder: checks set (R4) and holding (R5), then returns the batch (R8)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && fetch_req_valid) begin
                int fs, es;
                fs = int'(fetch_req_set);
                es = (fexq.size() > 0) ? fexq.pop_front() : -1;
                chk(fs == es, "R4", "fetch_req_set", fs, es);
                @(negedge clk);
                @(negedge clk);
                chk(fetch_req_valid === 1'b1 && int'(fetch_req_set) == fs, "R5",
                    "fetch held", int'(fetch_req_set), fs);
                fetch_req_ready = 1'b1;
                @(negedge clk);
                fetch_req_ready = 1'b0;
                repeat (FLAT) @(negedge clk);
                for (int w = 0; w < WAYS; w++) begin
                    fetch_rsp_tags[w*TAG_W +: TAG_W] = TAG_W'(btag(fs, w));
                    fetch_rsp_vld[w] = bvld(fs, w);
                end
                fetch_rsp_valid = 1'b1;
                @(negedge clk);
                fetch_rsp_valid = 1'b0;
                chk(fetch_req_valid === 1'b0, "R5", "single fetch", int'(fetch_req_valid), 0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: state under reset
        chk(req_ready === 1'b1, "R1", "req_ready", int'(req_ready), 1);
        chk(rsp_valid === 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
        chk(fetch_req_valid === 1'b0, "R1", "fetch_req_valid", int'(fetch_req_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R1", "after reset", int'(rsp_valid), 0);

        // R4/R6/R7/R10: leading miss, then same-set waiters while pending
        phase = "pending";
        send(5, 1, btag(5, 2));
        probe_ready(9, 1'b0, "R7");
        probe_ready(5, 1'b1, "R6");
        send(5, 2, btag(5, 3));
        send(5, 3, 12'hfff);
        send(5, 4, btag(5, 0));
        probe_ready(5, 1'b0, "R10");
        // R7 request to another set stalls until drain ends, then is leading
        send(9, 7, btag(9, 1));

        // R2/R3: resident hits and misses, invalid way counts as absent
        phase = "resident";
        send(5, 8, btag(5, 5));
        send(5, 9, btag(5, 6));
        send(9, 10, 12'h7ff);

        // R9: fill, evict the least recent, revisit the evicted set
        phase = "replace";
        send(20, 11, btag(20, 4));
        send(33, 12, btag(33, 7));
        send(9, 13, btag(9, 2));
        send(40, 14, btag(40, 1));
        send(5, 15, btag(5, 1));
        send(9, 16, btag(9, 3));
        send(20, 17, btag(20, 0));

        // Mixed traffic over six sets
        phase = "mixed";
        for (int i = 0; i < 60; i++) begin
            int sets[6] = '{5, 9, 20, 33, 40, 51};
            int s;
            s = sets[(i * 7 + 3) % 6];
            send(s, i % 64, (i % 3 == 0) ? 12'hfff : btag(s, i % 8));
        end

        for (int t = 0; t < 400 && exq.size() > 0; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exq.size() == 0, "R6", "answers outstanding", exq.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule